// File: doc/BRIEF.md
# Configurable-Format Serial Character Transmitter

This block turns one parallel character into one asynchronous serial frame on a transmit line that rests at logic high. A producer offers a character with a valid/ready handshake. The frame format comes from a small line-control field that is sampled together with the character. The field sets the data width (5 to 8 bits), whether a parity bit follows the data, whether that parity is odd or even, and the stop period. A one-cycle strobe at sixteen times the bit rate paces the whole frame.

The input is a standard valid/ready stream. A character and its format move across only on a clock edge where `in_valid_i` and `in_ready_o` are both high. The producer must hold the character and the format steady while it waits. `in_ready_o` stays low for the whole frame, so this back-pressure is the only flow control. The block holds no queue: while a frame is running, an offered character is neither stored nor lost, and it stays with the producer.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, `txd_o` is 1 and `in_ready_o` is 1, and the line stays high for as long as no frame is running.
- R2: A character is accepted on an edge where `in_valid_i` and `in_ready_o` are both 1. `in_ready_o` is 0 from the next cycle until the last tick of the final stop period. It returns to 1 in the cycle after that tick. Valid strobes during a frame have no effect.
- R3: `fmt_i[1:0]` sets the data width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: A frame is a start bit at 0, then the data bits least-significant first, then the optional parity bit, then the stop period at 1. Every start, data and parity bit lasts exactly 16 ticks of `tick16_i`. The line goes low in the cycle after acceptance.
- R5: With `fmt_i[3]` = 1, one parity bit follows the last data bit. With `fmt_i[3]` = 0, no parity bit is sent.
- R6: `fmt_i[4]` = 0 selects odd parity, so the data bits plus the parity bit hold an odd number of ones. `fmt_i[4]` = 1 selects even parity.
- R7: With `fmt_i[2]` = 0, the stop period is one bit, which is 16 ticks, for every data width.
- R8: With `fmt_i[2]` = 1 and a 5-bit width, the stop period is one and a half bits, which is 24 ticks.
- R9: With `fmt_i[2]` = 1 and a width of 6, 7 or 8 bits, the stop period is two bits, which is 32 ticks.
- R10: Data bits above the selected width are not sent and do not enter the parity.
- R11: The format is captured at acceptance. A change on `fmt_i` during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle strobe at 16x the bit rate |
| fmt_i | input | 5 | Line-control field: [1:0] width, [2] long stop, [3] parity on, [4] even parity |
| in_data_i | input | 8 | Character to send |
| in_valid_i | input | 1 | Character offered |
| in_ready_o | output | 1 | Block idle; it accepts a character on this edge |
| txd_o | output | 1 | Serial line, idle high |

## Verification
The line drops to the start level in the cycle after the accepting edge. Each later change of `txd_o` appears in the cycle after the tick that ends the current bit. `in_ready_o` rises in the cycle after the last tick of the stop period. So after tick number k (counted from acceptance), the line must show frame position k and nothing else. The bench samples `txd_o` and `in_ready_o` on the falling edge that follows each tick. It compares the samples with a per-tick frame image that it builds on its own from the format and the data. It also takes one sample at acceptance, before any tick, and one at tick T, where idle must be back.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } tx_phase_e;

  // Decoded frame format, captured at acceptance.
  typedef struct packed {
    logic [3:0] nbits;       // data bits, 5..8
    logic       par_on;      // parity bit present
    logic       par_even;    // 1: even, 0: odd
    logic [1:0] stop_slots;  // number of stop slots, 1 or 2
    logic       half_tail;   // final stop slot is half length
  } tx_fmt_t;

endpackage

// File: rtl/tx_fmt_decode.sv
module tx_fmt_decode
  import serial_tx_pkg::*;
(
  input  logic [4:0] ctrl_i,
  output tx_fmt_t    fmt_o
);

  logic long_stop;
  logic shortest;

  assign long_stop = ctrl_i[2];
  assign shortest  = (ctrl_i[1:0] == 2'b00);

  always_comb begin
    fmt_o.nbits      = 4'd5 + {2'b00, ctrl_i[1:0]};
    fmt_o.par_on     = ctrl_i[3];
    fmt_o.par_even   = ctrl_i[4];
    fmt_o.stop_slots = long_stop ? 2'd2 : 2'd1;
    // R8: a 5-bit word with a long stop ends on a half slot (1.5 bits)
    fmt_o.half_tail  = long_stop & shortest;
  end

endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
  parameter int DATA_W = 8,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              even_i,
  output logic [DATA_W-1:0] masked_o,
  output logic              parity_o
);

  // R10: bits at or above the selected width are cleared
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked_o[i] = data_i[i] & (NB_W'(i) < nbits_i);
  end

  // R6: odd parity inverts the XOR reduction
  assign parity_o = (^masked_o) ^ ~even_i;

endmodule

// File: rtl/tx_slot_timer.sv
module tx_slot_timer #(
  parameter int OVS   = 16,
  localparam int CW   = $clog2(OVS),
  localparam int HALF = OVS / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic tick_i,
  input  logic half_i,
  output logic done_o
);

  localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = half_i ? HALF_LAST : FULL_LAST;
  assign done_o = !hold_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hold_i || done_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic [4:0]        fmt_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              txd_o
);

  localparam int NB_W = $clog2(DATA_W + 1);

  tx_phase_e         phase_q;
  tx_fmt_t           fmt_d, fmt_q;
  logic [DATA_W-1:0] shift_q, masked;
  logic [NB_W-1:0]   bit_q;
  logic [1:0]        stop_q;
  logic              par_d, par_q;
  logic              accept, slot_done, last_stop, half_now;

  tx_fmt_decode u_dec (
    .ctrl_i (fmt_i),
    .fmt_o  (fmt_d)
  );

  tx_parity_gen #(.DATA_W(DATA_W)) u_par (
    .data_i   (in_data_i),
    .nbits_i  (NB_W'(fmt_d.nbits)),
    .even_i   (fmt_d.par_even),
    .masked_o (masked),
    .parity_o (par_d)
  );

  assign last_stop = (stop_q == fmt_q.stop_slots - 2'd1);
  assign half_now  = (phase_q == PH_STOP) && last_stop && fmt_q.half_tail;

  tx_slot_timer #(.OVS(OVS)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (phase_q == PH_IDLE),
    .tick_i (tick16_i),
    .half_i (half_now),
    .done_o (slot_done)
  );

  assign in_ready_o = (phase_q == PH_IDLE);
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      fmt_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      bit_q   <= '0;
      stop_q  <= '0;
    end else if (accept) begin
      // R11: format frozen here for the whole frame
      phase_q <= PH_START;
      fmt_q   <= fmt_d;
      shift_q <= masked;
      par_q   <= par_d;
      bit_q   <= '0;
      stop_q  <= '0;
    end else if (slot_done) begin
      unique case (phase_q)
        PH_START: begin
          phase_q <= PH_DATA;
          bit_q   <= '0;
        end
        PH_DATA: begin
          shift_q <= shift_q >> 1;
          if (bit_q == NB_W'(fmt_q.nbits) - 1'b1) begin
            phase_q <= fmt_q.par_on ? PH_PARITY : PH_STOP;
            stop_q  <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        PH_PARITY: begin
          phase_q <= PH_STOP;
          stop_q  <= '0;
        end
        PH_STOP: begin
          if (last_stop) phase_q <= PH_IDLE;
          else           stop_q  <= stop_q + 2'd1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START:  txd_o = 1'b0;
      PH_DATA:   txd_o = shift_q[0];
      PH_PARITY: txd_o = par_q;
      default:   txd_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/serial_char_tx_chk.sv
module serial_char_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick16_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic txd_o
);

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> txd_o);

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (!in_ready_o && !txd_o));

  p_ready_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> $past(tick16_i));

  p_line_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick16_i && !in_ready_o) |=> ($stable(txd_o) && !in_ready_o));

  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> !txd_o);

endmodule

bind serial_char_tx serial_char_tx_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick16_i   (tick16_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .txd_o      (txd_o)
);

// File: tb/serial_char_tx_tb_top.sv
`timescale 1ns/1ps
module serial_char_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [4:0] fmt = '0;
  logic [7:0] din = '0;
  logic       vld = 1'b0;
  logic       rdy, txd;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic exp_line [0:255];
  int   exp_len;

  always #2 clk = ~clk;

  serial_char_tx dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick16_i   (tick),
    .fmt_i      (fmt),
    .in_data_i  (din),
    .in_valid_i (vld),
    .in_ready_o (rdy),
    .txd_o      (txd)
  );

  // tick high for one cycle in every four
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 4 == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Build the per-tick frame image from the requirements.
  task automatic build(input logic [4:0] f, input logic [7:0] d);
    int ln = 5 + f[1:0];
    int ix = 0;
    int ones = 0;
    logic p;
    for (int i = 0; i < 16; i++) exp_line[ix++] = 1'b0;
    for (int b = 0; b < ln; b++) begin
      ones += d[b];
      for (int i = 0; i < 16; i++) exp_line[ix++] = d[b];
    end
    if (f[3]) begin
      p = f[4] ? (ones % 2 == 1) : (ones % 2 == 0);
      for (int i = 0; i < 16; i++) exp_line[ix++] = p;
    end
    begin
      int st = !f[2] ? 16 : (ln == 5 ? 24 : 32);
      for (int i = 0; i < st; i++) exp_line[ix++] = 1'b1;
    end
    exp_len = ix;
  endtask

  // Send one frame. alt_fmt is put on fmt at tick 40 when chg is set.
  // With inj set, a second valid is offered from tick 20 to tick 60.
  task automatic run_frame(input logic [4:0] f, input logic [7:0] d, input string req,
                           input bit chg, input logic [4:0] alt_fmt, input bit inj);
    int line_err = 0, rdy_err = 0, first_k = -1, act_v = 0, exp_v = 0;
    build(f, d);
    @(negedge clk);
    fmt = f; din = d; vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    for (int k = 0; k <= exp_len; k++) begin
      if (k > 0) begin
        do @(posedge clk); while (!tick);
        @(negedge clk);
      end
      if (k < exp_len) begin
        if (txd !== exp_line[k]) begin
          line_err++;
          if (first_k < 0) begin first_k = k; act_v = txd; exp_v = exp_line[k]; end
        end
        if (rdy !== 1'b0) rdy_err++;
      end else begin
        if (txd !== 1'b1 || rdy !== 1'b1) rdy_err++;
      end
      if (chg && k == 40) fmt = alt_fmt;
      if (inj && k == 20) begin din = ~d; vld = 1'b1; end
      if (inj && k == 60) vld = 1'b0;
    end
    if (first_k >= 0) $display("  first line mismatch at tick %0d", first_k);
    chk(line_err == 0, {req, " line"}, act_v, exp_v);
    chk(rdy_err == 0, {req, " R2 ready/idle timing"}, rdy_err, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rdy === 1'b1, "R1 ready after reset", rdy, 1);
    chk(txd === 1'b1, "R1 line idle", txd, 1);
  endtask

  task automatic t_widths;   // R3 R4 R7
    run_frame(5'b00000, 8'h15, "R3 5-bit", 1'b0, '0, 1'b0);
    run_frame(5'b00001, 8'h2A, "R3 6-bit", 1'b0, '0, 1'b0);
    run_frame(5'b00010, 8'h4D, "R3 7-bit", 1'b0, '0, 1'b0);
    run_frame(5'b00011, 8'hB1, "R4 R7 8-bit", 1'b0, '0, 1'b0);
  endtask

  task automatic t_parity;   // R5 R6
    run_frame(5'b01011, 8'hA5, "R6 odd even-ones", 1'b0, '0, 1'b0);
    run_frame(5'b01011, 8'h07, "R6 odd odd-ones", 1'b0, '0, 1'b0);
    run_frame(5'b11011, 8'h07, "R6 even odd-ones", 1'b0, '0, 1'b0);
    run_frame(5'b11010, 8'h00, "R5 even zero", 1'b0, '0, 1'b0);
  endtask

  task automatic t_stops;    // R8 R9
    run_frame(5'b00100, 8'h0B, "R8 5-bit 1.5 stop", 1'b0, '0, 1'b0);
    run_frame(5'b01100, 8'h1C, "R8 5-bit par 1.5 stop", 1'b0, '0, 1'b0);
    run_frame(5'b00101, 8'h33, "R9 6-bit 2 stop", 1'b0, '0, 1'b0);
    run_frame(5'b00111, 8'hC3, "R9 8-bit 2 stop", 1'b0, '0, 1'b0);
  endtask

  task automatic t_upper;    // R10
    run_frame(5'b01000, 8'hE0 | 8'h09, "R10 5-bit high bits ignored", 1'b0, '0, 1'b0);
    run_frame(5'b11001, 8'hC0 | 8'h01, "R10 6-bit high bits ignored", 1'b0, '0, 1'b0);
  endtask

  task automatic t_latch;    // R11
    run_frame(5'b00000, 8'h1E, "R11 format change mid-frame", 1'b1, 5'b11111, 1'b0);
  endtask

  task automatic t_busy;     // R2
    run_frame(5'b00011, 8'h5A, "R2 valid while busy", 1'b0, '0, 1'b1);
    repeat (80) @(negedge clk);
    chk(txd === 1'b1 && rdy === 1'b1, "R2 no frame from busy valid", txd, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_widths();
    t_parity();
    t_stops();
    t_upper();
    t_latch();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule